// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects interrupt events from up to a parameterized number of peripheral sources and presents one request line to the CPU. Each source delivers a single-cycle set pulse; the block latches it in a status register, where it stays until software acknowledges it. A second register, the mask, selects which latched events are allowed to reach the CPU. The request output is high whenever any latched event is also enabled.

Both registers sit in a small register window and can be reached with 32-bit or 16-bit accesses. Software acknowledges events by writing the status register with a word that has zeros at the events to be cleared and ones everywhere else. The stored status is ANDed with that word, so a set bit can never be created by software. A mask write replaces the mask outright. Because the request is formed combinationally from the stored registers, the new mask takes effect on the request in the cycle that follows the write. By convention, source input 3 carries the DMA controller's interrupt.

Top module: `irq_stat_mask_top`

## Requirements
- R1: After reset, status and mask both read as zero and `irq_out` is low.
- R2: A pulse on `src_set[i]` makes status bit i read as 1 from the next cycle on. A status bit never becomes 1 without such a pulse.
- R3: A write to the status register ANDs the stored status with the written bits. Bits written as 1 keep their value and bits written as 0 are cleared.
- R4: If a set pulse and an acknowledge (a written 0) reach the same status bit in the same cycle, the bit ends up set.
- R5: A write to the mask register replaces every written mask bit with the written value. Mask bits outside the written lane, and the whole mask when there is no mask write, keep their value.
- R6: `irq_out` equals the OR over all bits of (status AND mask), formed without a register. After a mask write that enables a pending status bit, it is high in the first cycle after the write.
- R7: The status register is at byte offset 0x070 and the mask at 0x074. A 32-bit access (`bus_half`=0) needs offset bits 1:0 = 00 and carries register bits 31:0. A 16-bit access (`bus_half`=1) needs offset bit 0 = 0; offset bit 1 = 0 selects register bits 15:0 and offset bit 1 = 1 selects bits 31:16. Both travel in data bits 15:0, and `bus_rdata[31:16]` reads zero.
- R8: Register bits at and above NUM_SRC (11 by default) read as zero and ignore writes.
- R9: Reads have no side effects. Reads and writes to any other offset, or to a misaligned offset, return zero and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| src_set | input | NUM_SRC | Single-cycle set pulses, one per source; bit 3 is the DMA controller |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the register window |
| bus_half | input | 1 | 1 = 16-bit access, 0 = 32-bit access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when there is no read hit |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
The assertions assume that each source holds its set line for one cycle per event, and that `bus_we` only has meaning while `bus_en` is high. Set pulses may arrive on any cycle, including the cycle of an acknowledge. The random stimulus drives sparse, mostly single-cycle pulses on random sources. It spreads accesses over both registers, both halves, neighbouring offsets and misaligned offsets. Directed cases force a set and a clear onto the same bit in the same cycle, and a mask write over a status bit that is already pending.

// File: rtl/irq_stat_mask_pkg.sv
package irq_stat_mask_pkg;
  localparam int unsigned BUS_W     = 32;
  localparam int unsigned HALF_W    = 16;
  localparam int unsigned STAT_OFFS = 32'h070;
  localparam int unsigned MASK_OFFS = 32'h074;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_STAT = 2'd1,
    REG_MASK = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_acc_decode.sv
module irq_acc_decode
  import irq_stat_mask_pkg::*;
#(
  parameter int unsigned NUM_SRC = 11,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_half,
  input  logic [BUS_W-1:0]  bus_wdata,
  output reg_sel_e          sel,
  output logic              stat_we,
  output logic              mask_we,
  output logic [NUM_SRC-1:0] wr_lane,
  output logic [NUM_SRC-1:0] wr_word
);
  localparam logic [ADDR_W-3:0] STAT_IDX = ADDR_W'(STAT_OFFS) >> 2;
  localparam logic [ADDR_W-3:0] MASK_IDX = ADDR_W'(MASK_OFFS) >> 2;

  logic             aligned;
  logic [BUS_W-1:0] lane32;
  logic [BUS_W-1:0] word32;

  always_comb begin
    aligned = bus_half ? !bus_addr[0] : (bus_addr[1:0] == 2'b00);
    sel = REG_NONE;
    if (bus_en && aligned) begin
      if (bus_addr[ADDR_W-1:2] == STAT_IDX)      sel = REG_STAT;
      else if (bus_addr[ADDR_W-1:2] == MASK_IDX) sel = REG_MASK;
    end
    stat_we = bus_we && (sel == REG_STAT);
    mask_we = bus_we && (sel == REG_MASK);

    if (!bus_half) begin
      lane32 = '1;
      word32 = bus_wdata;
    end else if (bus_addr[1]) begin
      lane32 = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
      word32 = {bus_wdata[HALF_W-1:0], {HALF_W{1'b0}}};
    end else begin
      lane32 = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
      word32 = {{HALF_W{1'b0}}, bus_wdata[HALF_W-1:0]};
    end
    wr_lane = lane32[NUM_SRC-1:0];
    wr_word = word32[NUM_SRC-1:0];
  end

  generate
    if (NUM_SRC < BUS_W) begin : g_sink
      logic unused_hi;
      assign unused_hi = ^{lane32[BUS_W-1:NUM_SRC], word32[BUS_W-1:NUM_SRC]};
    end
  endgenerate

  always_comb begin
    if (stat_we || mask_we) begin
      AST_ONE_TARGET: assert (stat_we != mask_we);  // R7
    end
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic               stat_we,
  input  logic [NUM_SRC-1:0] wr_lane,
  input  logic [NUM_SRC-1:0] wr_word,
  output logic [NUM_SRC-1:0] status
);
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] status_d;
  logic [NUM_SRC-1:0] ack_clr;
  logic               status_en;

  always_comb begin
    ack_clr   = stat_we ? (wr_lane & ~wr_word) : '0;
    status_en = stat_we || (src_set != '0);
    status_d  = (status_q & ~ack_clr) | src_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (status_en) status_q <= status_d;
  end

  assign status = status_q;

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_set != '0) |=> ((status_q & $past(src_set)) == $past(src_set)));  // R4
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q | src_set)) == '0));  // R2
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> ((status_q & $past(wr_lane & ~wr_word & ~src_set)) == '0));  // R3
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_we,
  input  logic [NUM_SRC-1:0] wr_lane,
  input  logic [NUM_SRC-1:0] wr_word,
  output logic [NUM_SRC-1:0] mask
);
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] mask_d;

  always_comb begin
    mask_d = (mask_q & ~wr_lane) | (wr_word & wr_lane);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_d;
  end

  assign mask = mask_q;

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));  // R5
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (((mask_q ^ $past(wr_word)) & $past(wr_lane)) == '0));  // R5
endmodule

// File: rtl/irq_stat_mask_top.sv
module irq_stat_mask_top
  import irq_stat_mask_pkg::*;
#(
  parameter int unsigned NUM_SRC = 11,
  parameter int unsigned ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_set,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_half,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               irq_out
);
  localparam logic [BUS_W-1:0] IMPL_BITS = BUS_W'((64'd1 << NUM_SRC) - 64'd1);

  logic               rst_int_n;
  reg_sel_e           sel;
  logic               stat_we;
  logic               mask_we;
  logic [NUM_SRC-1:0] wr_lane;
  logic [NUM_SRC-1:0] wr_word;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] mask;
  logic [BUS_W-1:0]   stat_word;
  logic [BUS_W-1:0]   mask_word;
  logic [BUS_W-1:0]   rd_word;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  irq_acc_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_dec (
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_half(bus_half), .bus_wdata(bus_wdata), .sel(sel),
    .stat_we(stat_we), .mask_we(mask_we),
    .wr_lane(wr_lane), .wr_word(wr_word)
  );

  irq_status_reg #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk(clk), .rst_n(rst_int_n), .src_set(src_set), .stat_we(stat_we),
    .wr_lane(wr_lane), .wr_word(wr_word), .status(status)
  );

  irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk(clk), .rst_n(rst_int_n), .mask_we(mask_we),
    .wr_lane(wr_lane), .wr_word(wr_word), .mask(mask)
  );

  generate
    if (NUM_SRC < BUS_W) begin : g_pad
      assign stat_word = {{(BUS_W-NUM_SRC){1'b0}}, status};
      assign mask_word = {{(BUS_W-NUM_SRC){1'b0}}, mask};
    end else begin : g_full
      assign stat_word = status;
      assign mask_word = mask;
    end
  endgenerate

  always_comb begin
    unique case (sel)
      REG_STAT: rd_word = stat_word;
      REG_MASK: rd_word = mask_word;
      default:  rd_word = '0;
    endcase
    if (bus_we)        bus_rdata = '0;
    else if (bus_half) bus_rdata = {{HALF_W{1'b0}},
                                    bus_addr[1] ? rd_word[BUS_W-1:HALF_W] : rd_word[HALF_W-1:0]};
    else               bus_rdata = rd_word;
  end

  assign irq_out = |(status & mask);

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_en && !bus_half) |-> ((bus_rdata & ~IMPL_BITS) == '0));  // R8
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(irq_out) |-> $past(bus_en && bus_we));  // R6
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_en && sel == REG_NONE) |-> (bus_rdata == '0));  // R9
endmodule

// File: tb/irq_stat_mask_top_tb_top.sv
module irq_stat_mask_top_tb_top;
  localparam int NS = 11;
  localparam int AW = 12;
  localparam logic [31:0] IMPL = (32'd1 << NS) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_set = '0;
  logic          bus_en = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_half = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m_st = '0;
  logic [31:0] m_mk = '0;

  always #2.5 clk = ~clk;

  irq_stat_mask_top #(.NUM_SRC(NS), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .bus_en(bus_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_half(bus_half),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // 0 = status, 1 = mask, 2 = none (R7, R9)
  function automatic int target(input logic [AW-1:0] a, input logic half);
    logic ok;
    ok = half ? !a[0] : (a[1:0] == 2'b00);
    if (!ok) return 2;
    if (a[AW-1:2] == 10'h01C) return 0;
    if (a[AW-1:2] == 10'h01D) return 1;
    return 2;
  endfunction

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a, input logic half);
    logic [31:0] w;
    int t;
    t = target(a, half);
    w = (t == 0) ? m_st : (t == 1) ? m_mk : 32'h0;
    if (half) return {16'h0, a[1] ? w[31:16] : w[15:0]};
    return w;
  endfunction

  task automatic op(input logic en, input logic we, input logic [AW-1:0] a,
                    input logic half, input logic [31:0] wd, input logic [NS-1:0] set,
                    input string rtag);
    logic [31:0] lane, word;
    int t;
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = a; bus_half = half; bus_wdata = wd;
    src_set = set;
    #1;
    if (en && !we) check(rtag, bus_rdata, exp_read(a, half));
    check("R6 irq", {31'h0, irq_out}, {31'h0, |(m_st & m_mk)});
    @(posedge clk);
    t = target(a, half);
    if (!half) begin lane = '1; word = wd; end
    else if (a[1]) begin lane = 32'hFFFF0000; word = {wd[15:0], 16'h0}; end
    else begin lane = 32'h0000FFFF; word = {16'h0, wd[15:0]}; end
    if (en && we && t == 0) m_st = m_st & ~(lane & ~word);
    if (en && we && t == 1) m_mk = ((m_mk & ~lane) | (word & lane)) & IMPL;
    m_st = (m_st | {21'h0, set}) & IMPL;
  endtask

  task automatic idle_check(input string rtag, input logic [AW-1:0] a, input logic half);
    op(1'b1, 1'b0, a, half, 32'h0, '0, rtag);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] addrs [6];
    addrs = '{12'h070, 12'h072, 12'h074, 12'h076, 12'h078, 12'h071};
    void'($urandom(32'h1A5C0DE));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    idle_check("R1 status", 12'h070, 1'b0);
    idle_check("R1 mask", 12'h074, 1'b0);
    check("R1 irq", {31'h0, irq_out}, 32'h0);

    // R2 set on DMA source (bit 3), R6 irq once mask enabled
    op(1'b0, 1'b0, 12'h0, 1'b0, 32'h0, 11'h008, "R2");
    idle_check("R2 bit3 set", 12'h070, 1'b0);
    op(1'b1, 1'b1, 12'h074, 1'b0, 32'h0000_0008, '0, "R6");
    @(negedge clk); #1;
    check("R6 irq after mask write", {31'h0, irq_out}, 32'h1);

    // R8 unimplemented bits
    op(1'b1, 1'b1, 12'h074, 1'b0, 32'hFFFF_FFFF, '0, "R8");
    idle_check("R8 mask upper zero", 12'h074, 1'b0);
    // R7 16-bit upper half write of zeros to mask: no implemented bit
    op(1'b1, 1'b1, 12'h076, 1'b1, 32'h0, '0, "R7");
    idle_check("R7 half read low", 12'h074, 1'b1);
    idle_check("R7 half read high", 12'h076, 1'b1);

    // R4 set and clear same bit same cycle
    op(1'b1, 1'b1, 12'h070, 1'b0, 32'hFFFF_FFDF, 11'h020, "R4");
    idle_check("R4 set wins", 12'h070, 1'b0);
    // R3 acknowledge bit 5 only
    op(1'b1, 1'b1, 12'h070, 1'b1, 32'h0000_FFDF, '0, "R3");
    idle_check("R3 ack bit5", 12'h070, 1'b0);
    // R9 write to other offset and misaligned
    op(1'b1, 1'b1, 12'h078, 1'b0, 32'h0, '0, "R9");
    op(1'b1, 1'b1, 12'h071, 1'b1, 32'h0, '0, "R9");
    idle_check("R9 status unchanged", 12'h070, 1'b0);
    idle_check("R9 other reads zero", 12'h078, 1'b0);
    // R5 mask replace via 16-bit low half
    op(1'b1, 1'b1, 12'h074, 1'b1, 32'hABCD_0123, '0, "R5");
    idle_check("R5 mask replaced", 12'h074, 1'b0);

    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      logic [NS-1:0] s;
      a = addrs[$urandom_range(0, 5)];
      s = NS'($urandom & $urandom & $urandom & $urandom);
      op(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), a,
         1'($urandom_range(0, 1)), $urandom, s, "R2 R3 R5 R7 R8 R9 random");
    end
    idle_check("R2 final status", 12'h070, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule